// File: doc/BRIEF.md
# Programmable Periodic Soft-Trigger Generator

This block produces a repeating trigger pulse, one clock cycle wide, whose spacing comes from an 8-bit rate multiplier. The spacing is a fixed base interval plus the multiplier times a fixed step. At the default parameters and a 25 MHz clock, the base is 25 ms and the step is 12.5 ms. A multiplier of zero therefore gives about 40 Hz, and a multiplier of all ones gives about 0.3 Hz. The periodic pulse runs only while its run enable is high.

The periodic pulse is ORed with a one-shot software trigger and an external trigger. The combined line is then passed only while a global trigger-accept input is high. The register that holds the multiplier and the command path that writes it sit outside this block, and both are seen here only as inputs. By convention the multiplier register leaves reset at all ones, the slowest rate, and the trigger-accept input leaves reset low.

Top module: `soft_trigger_gen`

## Requirements
- R1: While `run_en` is low, no periodic pulse is produced and the interval counter is held at zero.
- R2: The periodic interval is P = BASE_CYC + `rate_mult` × STEP_CYC clock cycles. The defaults are 625000 and 312500 cycles.
- R3: Each periodic pulse is exactly one clock cycle wide.
- R4: The first pulse after `run_en` rises is produced by the P-th rising edge that samples `run_en` high. Later pulses follow every P cycles. Dropping and raising `run_en` restarts the count. `rate_mult` must be steady for at least one edge before `run_en` rises.
- R5: A change of `rate_mult` while running leaves the interval in progress unchanged. The new value applies from the next pulse boundary.
- R6: `trig_out` is the OR of the periodic pulse, `sw_pulse` and `ext_trig`. With OUT_MODE combinational, the software and external inputs reach `trig_out` in the same cycle.
- R7: While `trig_en` is low, `trig_out` stays low whatever the three sources do.
- R8: During and directly after reset, `trig_out` is low when all inputs are low.
- R9: A multiplier of all ones gives the longest interval, BASE_CYC + 255 × STEP_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 25 MHz in the intended system |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enables continuous periodic generation |
| rate_mult | input | MULT_W | Rate multiplier; each step adds STEP_CYC cycles |
| sw_pulse | input | 1 | One-shot software trigger |
| ext_trig | input | 1 | External trigger |
| trig_en | input | 1 | Global trigger accept gate |
| trig_out | output | 1 | Merged, gated trigger |

## Verification
A pulse launched by the edge that finds the counter at P−1 is visible in the half cycle after that edge. The bench counts rising edges and samples `trig_out` only on falling edges. It then requires the k-th pulse at edge index s + k·P − 1, where s is the first edge that sees `run_en` high. Software and external triggers take a combinational path, so their effect is checked one time unit after each falling-edge drive, within the same cycle. For the multiplier change, the bench expects one more interval at the old spacing and then the new spacing, both counted from the same edge index.

// File: rtl/softtrig_pkg.sv
package softtrig_pkg;

   // selects how the merged trigger leaves the block
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

   // the three trigger sources that are merged
   typedef struct packed {
      logic periodic;
      logic oneshot;
      logic external;
   } trig_src_t;

   function automatic bit is_pow2(input longint v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/stg_period_calc.sv
module stg_period_calc #(
   parameter int MULT_W   = 8,
   parameter int BASE_CYC = 625000,
   parameter int STEP_CYC = 312500,
   parameter int PW       = 27
) (
   input  logic [MULT_W-1:0] mult,
   output logic [PW-1:0]     period
);
   import softtrig_pkg::*;

   localparam bit STEP_IS_POW2 = is_pow2(longint'(STEP_CYC));
   localparam int STEP_SHIFT   = $clog2(STEP_CYC);

   logic [PW-1:0] mult_ext;
   logic [PW-1:0] scaled;

   assign mult_ext = PW'(mult);

   generate
      if (STEP_IS_POW2) begin : g_shift
         assign scaled = mult_ext << STEP_SHIFT;
      end else begin : g_mul
         assign scaled = mult_ext * PW'(STEP_CYC);
      end
   endgenerate

   assign period = PW'(BASE_CYC) + scaled;

endmodule

// File: rtl/stg_interval_timer.sv
module stg_interval_timer #(
   parameter int PW         = 27,
   parameter int RST_PERIOD = 80312500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [PW-1:0] next_period,
   output logic          tick
);
   logic [PW-1:0] cnt_q;
   logic [PW-1:0] period_q;
   logic          at_end;

   assign at_end = (cnt_q == period_q - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         period_q <= PW'(RST_PERIOD);
         tick     <= 1'b0;
      end else if (!run_en) begin
         cnt_q    <= '0;
         period_q <= next_period;
         tick     <= 1'b0;
      end else if (at_end) begin
         cnt_q    <= '0;
         period_q <= next_period;
         tick     <= 1'b1;
      end else begin
         cnt_q    <= cnt_q + PW'(1);
         tick     <= 1'b0;
      end
   end

   // R3
   tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R1
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!tick && cnt_q == '0));

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> (cnt_q < period_q));

   // R5
   period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !at_end) |=> $stable(period_q));

endmodule

// File: rtl/stg_merge.sv
module stg_merge #(
   parameter softtrig_pkg::out_mode_e OUT_MODE = softtrig_pkg::OUT_COMB
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  softtrig_pkg::trig_src_t src,
   input  logic                    trig_en,
   output logic                    trig_out
);
   import softtrig_pkg::*;

   logic any_src;

   assign any_src = src.periodic | src.oneshot | src.external;

   generate
      if (OUT_MODE == OUT_REG) begin : g_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= any_src & trig_en;
         end
         assign trig_out = out_q;

         // R7
         gate_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_en |=> !trig_out);
      end else begin : g_comb
         assign trig_out = any_src & trig_en;

         // R7
         gate_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_en |-> !trig_out);

         // R6
         merge_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_en && (src.oneshot || src.external)) |-> trig_out);
      end
   endgenerate

endmodule

// File: rtl/soft_trigger_gen.sv
module soft_trigger_gen #(
   parameter int                      MULT_W   = 8,
   parameter int                      BASE_CYC = 625000,
   parameter int                      STEP_CYC = 312500,
   parameter softtrig_pkg::out_mode_e OUT_MODE = softtrig_pkg::OUT_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [MULT_W-1:0] rate_mult,
   input  logic              sw_pulse,
   input  logic              ext_trig,
   input  logic              trig_en,
   output logic              trig_out
);
   import softtrig_pkg::*;

   localparam longint MAX_MULT   = (longint'(1) << MULT_W) - 1;
   localparam longint MAX_PERIOD = longint'(BASE_CYC) + MAX_MULT * longint'(STEP_CYC);
   localparam int     PW         = $clog2(MAX_PERIOD + 1);

   generate
      if (MULT_W < 1 || MULT_W > 16) begin : g_bad_mult_w
         $error("soft_trigger_gen: MULT_W must lie in 1..16");
      end
      if (BASE_CYC < 2) begin : g_bad_base
         $error("soft_trigger_gen: BASE_CYC must be at least 2");
      end
      if (STEP_CYC < 1) begin : g_bad_step
         $error("soft_trigger_gen: STEP_CYC must be at least 1");
      end
      if (PW > 40) begin : g_bad_width
         $error("soft_trigger_gen: longest period too wide");
      end
   endgenerate

   logic [PW-1:0] next_period;
   logic          tick;
   trig_src_t     src;

   stg_period_calc #(
      .MULT_W   (MULT_W),
      .BASE_CYC (BASE_CYC),
      .STEP_CYC (STEP_CYC),
      .PW       (PW)
   ) u_period (
      .mult   (rate_mult),
      .period (next_period)
   );

   stg_interval_timer #(
      .PW         (PW),
      .RST_PERIOD (int'(MAX_PERIOD))
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .next_period (next_period),
      .tick        (tick)
   );

   assign src.periodic = tick;
   assign src.oneshot  = sw_pulse;
   assign src.external = ext_trig;

   stg_merge #(
      .OUT_MODE (OUT_MODE)
   ) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .trig_en  (trig_en),
      .trig_out (trig_out)
   );

   // R8
   quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !sw_pulse && !ext_trig) |-> !trig_out);

endmodule

// File: tb/test_soft_trigger_gen.sv
module test_soft_trigger_gen;
   localparam int BASE = 6;
   localparam int STEP = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [7:0] rate_mult = 8'hFF;
   logic       sw_pulse = 1'b0;
   logic       ext_trig = 1'b0;
   logic       trig_en = 1'b0;
   logic       trig_out;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   soft_trigger_gen #(
      .MULT_W   (8),
      .BASE_CYC (BASE),
      .STEP_CYC (STEP)
   ) i_soft_trigger_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .rate_mult (rate_mult),
      .sw_pulse  (sw_pulse),
      .ext_trig  (ext_trig),
      .trig_en   (trig_en),
      .trig_out  (trig_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // measures pulse positions for one multiplier value
   task automatic spacing(input int m, input int npulse, input string req);
      int p, s, seen, prev;
      p = BASE + m * STEP;
      @(negedge clk);
      run_en = 1'b0;
      rate_mult = 8'(m);
      repeat (3) @(negedge clk);
      run_en = 1'b1;
      s = cyc + 1;
      seen = 0;
      prev = 0;
      for (int k = 0; k < npulse * p + 1; k++) begin
         @(negedge clk);
         if (trig_out) begin
            chk(cyc == s + (seen + 1) * p - 1, req, cyc, s + (seen + 1) * p - 1);
            // R3 width
            chk(prev == 0, "R3", prev, 0);
            seen++;
         end
         prev = int'(trig_out);
      end
      chk(seen == npulse, req, seen, npulse);
      run_en = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int s, cnt;
      // R8 reset state
      repeat (3) @(negedge clk);
      chk(trig_out == 1'b0, "R8", int'(trig_out), 0);
      rst_n = 1'b1;
      trig_en = 1'b1;
      rate_mult = 8'd0;
      cnt = 0;
      repeat (40) begin
         @(negedge clk);
         if (trig_out) cnt++;
      end
      // R1 and R8: no pulses while run_en is low
      chk(cnt == 0, "R1", cnt, 0);

      // R6, R7: exhaustive sweep of one-shot, external and accept gate
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         sw_pulse = v[0];
         ext_trig = v[1];
         trig_en  = v[2];
         #1;
         chk(trig_out == (v[2] & (v[0] | v[1])), v[2] ? "R6" : "R7",
             int'(trig_out), int'(v[2] & (v[0] | v[1])));
      end
      @(negedge clk);
      sw_pulse = 1'b0;
      ext_trig = 1'b0;
      trig_en = 1'b1;

      // R2, R4: spacing for multipliers 0, 1 and 255 (R9)
      spacing(0, 4, "R2");
      spacing(1, 3, "R4");
      spacing(2, 3, "R2");
      spacing(255, 3, "R9");

      // R5: change the multiplier in the middle of an interval
      @(negedge clk);
      rate_mult = 8'd0;
      repeat (2) @(negedge clk);
      run_en = 1'b1;
      s = cyc + 1;
      while (!trig_out) @(negedge clk);
      chk(cyc == s + BASE - 1, "R5", cyc, s + BASE - 1);
      repeat (2) @(negedge clk);
      rate_mult = 8'd1;
      @(negedge clk);
      while (!trig_out) @(negedge clk);
      chk(cyc == s + 2 * BASE - 1, "R5", cyc, s + 2 * BASE - 1);
      @(negedge clk);
      while (!trig_out) @(negedge clk);
      chk(cyc == s + 2 * BASE + BASE + STEP - 1, "R5", cyc, s + 3 * BASE + STEP - 1);

      // R4: drop run_en mid-interval, the count restarts on re-enable
      @(negedge clk);
      run_en = 1'b0;
      rate_mult = 8'd0;
      repeat (2) @(negedge clk);
      run_en = 1'b1;
      repeat (3) @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      chk(trig_out == 1'b0, "R1", int'(trig_out), 0);
      @(negedge clk);
      run_en = 1'b1;
      s = cyc + 1;
      cnt = 0;
      while (!trig_out && cnt < 50) begin
         @(negedge clk);
         cnt++;
      end
      chk(cyc == s + BASE - 1, "R4", cyc, s + BASE - 1);

      // R6: periodic pulse merged with a held external trigger
      @(negedge clk);
      ext_trig = 1'b1;
      #1;
      chk(trig_out == 1'b1, "R6", int'(trig_out), 1);

      // R7: accept gate low blocks all three sources while running
      trig_en = 1'b0;
      sw_pulse = 1'b1;
      cnt = 0;
      repeat (3 * BASE) begin
         @(negedge clk);
         if (trig_out) cnt++;
      end
      chk(cnt == 0, "R7", cnt, 0);
      sw_pulse = 1'b0;
      ext_trig = 1'b0;
      trig_en = 1'b1;
      run_en = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule